// File: doc/BRIEF.md
# Branch-Capable Next-PC Fetch Unit

This block keeps the program counter of a single-cycle core and drives it out as the instruction fetch address. In every cycle it works out where the next instruction lives. Normally that is the following word, four bytes on. When the current instruction is a conditional branch and the datapath reports that the two compared operands are equal, the next address is a word-scaled, sign-extended 16-bit offset added to that sequential address.

Two adders work in parallel. One forms the sequential address. The other adds the shifted offset to that sequential sum. A two-way select then chooses one of them. The program counter register loads the chosen value on the rising clock edge, which is the same edge that clocks every other storage element of the core. A synchronous reset loads a configurable start vector. Instruction memory, operand comparison and jump targets are outside this block.

All address arithmetic wraps modulo 2^32. The control pins are plain level signals with no handshake. They are sampled on every rising edge, and the fetch address is never stalled.

Top module: `pc_fetch_seq`

## Requirements
- R1: On a rising edge with `rst_i` high, the PC is loaded with `RESET_VEC` (default 0x00000000). `iaddr_o` shows that value until the next edge.
- R2: When `br_sel_i` is low at a rising edge, the PC advances by 4 whatever the values of `eq_i` and `br_off_i`.
- R3: When `br_sel_i` is high and `eq_i` is low at a rising edge, the PC advances by 4.
- R4: When `br_sel_i` and `eq_i` are both high at a rising edge, the PC becomes PC + 4 + (sign-extended `br_off_i` shifted left by 2). Bit 15 of `br_off_i` is the sign bit.
- R5: A taken branch with `br_off_i` = 0xFFFF (offset -1) leaves the PC unchanged, so the instruction loops on itself for as long as the branch stays taken.
- R6: All sums wrap modulo 2^32. A taken branch from 0x00000000 with offset 0xFFFE gives 0xFFFFFFFC, and the next sequential step from 0xFFFFFFFC gives 0x00000000.
- R7: The offset extremes are exact. 0x7FFF adds 4 + 131068 to the PC, and 0x8000 adds 4 - 131072.
- R8: Reset takes priority over a taken branch that is presented in the same cycle.
- R9: With a word-aligned `RESET_VEC`, bits [1:0] of `iaddr_o` stay zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| br_sel_i | input | 1 | Current instruction is a conditional branch |
| eq_i | input | 1 | Operand equality condition from the datapath |
| br_off_i | input | 16 | Signed branch word offset from the instruction |
| iaddr_o | output | 32 | Current PC, used as the instruction memory address |

## Verification
Every result is due exactly one clock edge after its stimulus. The inputs that are present at rising edge k fix the value `iaddr_o` holds from that edge until edge k+1, and no other register lies on the path. The bench changes the inputs at the falling edge and lets a single rising edge pass. At the next falling edge it compares `iaddr_o` with a model PC that the bench advanced by the same rule. Because the model state moves forward once per edge, a wrong value in one cycle also shows up in every later comparison until the next reset.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  // source chosen for the next program counter
  typedef enum logic {
    NXT_SEQ = 1'b0,
    NXT_BR  = 1'b1
  } pcf_src_e;
endpackage

// File: rtl/pcf_seq_add.sv
module pcf_seq_add #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] seq_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  // wraps modulo 2^AW
  assign seq_o = pc_i + STEP_V;
endmodule

// File: rtl/pcf_tgt_add.sv
module pcf_tgt_add #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int SH = 2
) (
  input  logic [AW-1:0] seq_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] tgt_o
);
  localparam int EXT_W = AW - OW;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] off_scaled;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{off_i[OW-1]}}, off_i};
    end else begin : g_trunc
      assign off_ext = off_i[AW-1:0];
    end
  endgenerate

  assign off_scaled = off_ext << SH;
  assign tgt_o      = seq_i + off_scaled;
endmodule

// File: rtl/pcf_next_sel.sv
module pcf_next_sel
  import pcf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          br_sel_i,
  input  logic          eq_i,
  input  logic [AW-1:0] seq_i,
  input  logic [AW-1:0] tgt_i,
  output pcf_src_e      src_o,
  output logic [AW-1:0] nxt_o
);
  always_comb begin
    src_o = (br_sel_i && eq_i) ? NXT_BR : NXT_SEQ;
    unique case (src_o)
      NXT_BR:  nxt_o = tgt_i;
      default: nxt_o = seq_i;
    endcase
  end
endmodule

// File: rtl/pc_fetch_seq.sv
module pc_fetch_seq
  import pcf_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          OW        = 16,
  parameter int          STEP      = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          br_sel_i,
  input  logic          eq_i,
  input  logic [OW-1:0] br_off_i,
  output logic [AW-1:0] iaddr_o
);
  localparam int            SH    = $clog2(STEP);
  localparam logic [AW-1:0] RST_V = AW'(RESET_VEC);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] tgt_addr;
  logic [AW-1:0] nxt_addr;
  pcf_src_e      nxt_src;

  pcf_seq_add #(.AW(AW), .STEP(STEP)) u_seq (
    .pc_i  (pc_q),
    .seq_o (seq_addr)
  );

  pcf_tgt_add #(.AW(AW), .OW(OW), .SH(SH)) u_tgt (
    .seq_i (seq_addr),
    .off_i (br_off_i),
    .tgt_o (tgt_addr)
  );

  pcf_next_sel #(.AW(AW)) u_sel (
    .br_sel_i (br_sel_i),
    .eq_i     (eq_i),
    .seq_i    (seq_addr),
    .tgt_i    (tgt_addr),
    .src_o    (nxt_src),
    .nxt_o    (nxt_addr)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) pc_q <= RST_V;
    else       pc_q <= nxt_addr;
  end

  assign iaddr_o = pc_q;
endmodule

// File: rtl/pcf_chk.sv
module pcf_chk #(
  parameter int          AW        = 32,
  parameter int          OW        = 16,
  parameter int          STEP      = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          br_sel_i,
  input logic          eq_i,
  input logic [OW-1:0] br_off_i,
  input logic [AW-1:0] iaddr_o
);
  localparam int            SH    = $clog2(STEP);
  localparam logic [AW-1:0] STP_V = AW'(STEP);

  // set once a reset edge has been seen, so that $past refers to known values
  logic hist_q = 1'b0;
  always_ff @(posedge clk_i) if (rst_i) hist_q <= 1'b1;

  function automatic logic [AW-1:0] scaled(input logic [OW-1:0] o);
    logic [AW-1:0] e;
    e = AW'($signed(o));
    return e << SH;
  endfunction

  // R1
  reset_vec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && $past(rst_i)) |-> iaddr_o == AW'(RESET_VEC));

  // R2
  no_branch_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && !$past(rst_i) && !$past(br_sel_i)) |-> iaddr_o == $past(iaddr_o) + STP_V);

  // R3
  not_equal_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && !$past(rst_i) && $past(br_sel_i) && !$past(eq_i))
      |-> iaddr_o == $past(iaddr_o) + STP_V);

  // R4
  taken_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && !$past(rst_i) && $past(br_sel_i) && $past(eq_i))
      |-> iaddr_o == $past(iaddr_o) + STP_V + scaled($past(br_off_i)));

  // R5
  self_loop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && !$past(rst_i) && $past(br_sel_i) && $past(eq_i) && $past(br_off_i) == {OW{1'b1}})
      |-> $stable(iaddr_o));

  // R9
  word_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hist_q && RESET_VEC[1:0] == 2'b00) |-> iaddr_o[1:0] == 2'b00);
endmodule

bind pc_fetch_seq pcf_chk #(
  .AW(AW), .OW(OW), .STEP(STEP), .RESET_VEC(RESET_VEC)
) chk_i (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .br_sel_i (br_sel_i),
  .eq_i     (eq_i),
  .br_off_i (br_off_i),
  .iaddr_o  (iaddr_o)
);

// File: tb/pc_fetch_seq_tb.sv
`timescale 1ns/1ps
module pc_fetch_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic        br_sel_i = 1'b0;
  logic        eq_i = 1'b0;
  logic [15:0] br_off_i = 16'h0;
  logic [31:0] iaddr_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  logic [31:0] model_pc = 32'h0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pc_fetch_seq dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .br_sel_i(br_sel_i),
    .eq_i(eq_i), .br_off_i(br_off_i), .iaddr_o(iaddr_o)
  );

  function automatic logic [31:0] next_pc(input logic [31:0] pc, input logic s,
                                          input logic e, input logic [15:0] o);
    logic [31:0] d;
    d = (s && e) ? {{14{o[15]}}, o, 2'b00} : 32'h0;
    return pc + 32'd4 + d;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (iaddr_o !== exp) begin
      n_err++;
      $display("FAIL %s: iaddr_o=%h expected=%h", req, iaddr_o, exp);
    end
  endtask

  // present inputs at the falling edge, one rising edge, compare at next falling edge
  task automatic step(input logic r, input logic s, input logic e,
                      input logic [15:0] o, input string req);
    rst_i = r; br_sel_i = s; eq_i = e; br_off_i = o;
    @(posedge clk_i);
    model_pc = r ? 32'h0 : next_pc(model_pc, s, e, o);
    @(negedge clk_i);
    check(req, model_pc);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i);
    step(1'b1, 1'b0, 1'b0, 16'h0, "R1");
    step(1'b0, 1'b0, 1'b1, 16'h1234, "R2");      // eq alone: no branch
    step(1'b0, 1'b0, 1'b0, 16'hFFFF, "R2");
    step(1'b0, 1'b1, 1'b0, 16'h0040, "R3");      // select without equality
    step(1'b0, 1'b1, 1'b1, 16'h0010, "R4");      // +4+64
    check("R9", {iaddr_o[31:2], 2'b00});
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 16'hFFFF, "R5");
    step(1'b0, 1'b1, 1'b1, 16'h7FFF, "R7");
    step(1'b0, 1'b1, 1'b1, 16'h8000, "R7");
    step(1'b1, 1'b1, 1'b1, 16'h0100, "R8");      // reset beats taken branch
    step(1'b0, 1'b1, 1'b1, 16'hFFFE, "R6");
    check("R6", 32'hFFFF_FFFC);
    step(1'b0, 1'b0, 1'b0, 16'h0, "R6");
    check("R6", 32'h0000_0000);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[9:0] == 10'd7) step(1'b1, rv[10], rv[11], rv[31:16], "R8");
      else if (!rv[10])     step(1'b0, 1'b0, rv[11], rv[31:16], "R2");
      else if (!rv[11])     step(1'b0, 1'b1, 1'b0, rv[31:16], "R3");
      else                  step(1'b0, 1'b1, 1'b1, rv[31:16], "R4");
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(5ns * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule